// File: doc/BRIEF.md
# Byte Staging FIFO with Host Word Access

This block is a byte-wide staging buffer between a NAND transfer engine and a host bus port. A direction input selects which side fills it. In read direction the engine deposits one byte per cycle and the host drains 1, 2 or 4 bytes per access. In write direction the host deposits 1, 2 or 4 bytes per access and the engine drains one byte per cycle. Multi-byte host words use little-endian lane order: lane 0 (bits 7:0) is the oldest byte.

A single byte-counted level output tells software how much room there is. In read direction it gives the number of bytes ready for the host. In write direction it gives the number of free slots the host may still fill. The level is compared with a programmable threshold to raise an interrupt or DMA request. The block never reports underflow or overflow. A read from an empty buffer returns the most recently drained byte, copied into every lane. A write into a full buffer lands in the most recently filled slot.

Top module: `byte_fifo_host`

## Requirements
- R1: In read direction (`dir_i`=0), `fifo_ptr_o` equals the number of stored bytes. An engine push increments it. A host read of n bytes (n=1/2/4 for `host_size_i`=0/1/2, 3 treated as 4) decrements it by min(n, level).
- R2: In write direction (`dir_i`=1), `fifo_ptr_o` equals DEPTH minus the stored bytes. A host write of n bytes decrements it by min(n, level). An engine pop increments it.
- R3: Byte order is little-endian. On a host read, byte lane k (bits 8k+7:8k) carries the k-th oldest stored byte. On a host write, lane k is the k-th byte the engine later pops. `eng_rdata_o` shows the oldest byte.
- R4: A host read with the buffer empty returns the last byte previously drained by the host in every lane of the access. After reset that byte is 0x00.
- R5: A host read of n bytes with only m bytes stored (0<m<n) returns those m bytes in lanes 0..m-1. Each remaining lane of the access carries the m-th byte.
- R6: A host write of n bytes with f free slots (f<n) stores lanes 0..f-1. Lane n-1 then overwrites the slot filled last. With no free slot, lane n-1 replaces the most recently written byte and the level stays at 0.
- R7: `dma_req_o` is high exactly when `fifo_ptr_o` is greater than or equal to `thresh_i`.
- R8: Operations that do not match the direction change nothing: engine push in write direction, engine pop in read direction, host write in read direction, host read in write direction. An engine push into a full buffer and an engine pop from an empty buffer are also ignored.
- R9: Reset empties the buffer. `fifo_ptr_o` is then 0 in read direction and DEPTH in write direction.
- R10: A host access and an engine operation in the same cycle both take effect. Each is judged on the level at the start of the cycle.
- R11: `eng_ready_o` is high when the engine may act. In read direction that means the buffer is not full. In write direction it means the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0: engine fills and host drains; 1: host fills and engine drains |
| thresh_i | input | TW (7) | Request threshold in bytes |
| eng_push_i | input | 1 | Engine deposits `eng_wdata_i` (read direction) |
| eng_wdata_i | input | 8 | Engine byte in |
| eng_pop_i | input | 1 | Engine takes the oldest byte (write direction) |
| eng_rdata_o | output | 8 | Oldest stored byte |
| eng_ready_o | output | 1 | Engine side may act |
| host_req_i | input | 1 | Host access strobe, one access per cycle |
| host_we_i | input | 1 | 1 write, 0 read |
| host_size_i | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| host_wdata_i | input | 32 | Host write data, little-endian lanes |
| host_rdata_o | output | 32 | Host read data, valid in the cycle of the read |
| fifo_ptr_o | output | CW (7) | Bytes ready (read) or free slots (write) |
| dma_req_o | output | 1 | Level at or above threshold |

## Verification
A wrong level counter shows up as a `fifo_ptr_o` error one cycle after the faulty operation. It also moves `dma_req_o` and `eng_ready_o` in that cycle. A wrong head or tail pointer, or a faulty overwrite address, stays hidden until the affected byte reaches lane 0. That happens at most DEPTH bytes later, when the byte reaches a host read or `eng_rdata_o`. A corrupted last-byte register shows only on the next empty or short read, so the sweeps drain the buffer completely and then read past the end in every access size.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } fifo_dir_e;

  function automatic int unsigned lane_count(logic [1:0] size);
    case (size)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic [LANES-1:0]           wr_en_i,
  input  logic [LANES-1:0][AW-1:0]   wr_addr_i,
  input  logic [LANES-1:0][7:0]      wr_data_i,
  input  logic [AW-1:0]              rd_base_i,
  output logic [LANES-1:0][7:0]      rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  // higher lane wins on address collision (overwrite path relies on this)
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_en_i[k]) mem_q[wr_addr_i[k]] <= wr_data_i[k];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_base_i + AW'(g)];
  end
endmodule

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned LW    = $clog2(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dir_i,
  input  logic                     eng_push_i,
  input  logic [7:0]               eng_wdata_i,
  input  logic                     eng_pop_i,
  input  logic                     host_req_i,
  input  logic                     host_we_i,
  input  logic [1:0]               host_size_i,
  input  logic [31:0]              host_wdata_i,
  input  logic [LANES-1:0][7:0]    rd_lanes_i,
  output logic [LANES-1:0]         wr_en_o,
  output logic [LANES-1:0][AW-1:0] wr_addr_o,
  output logic [LANES-1:0][7:0]    wr_data_o,
  output logic [AW-1:0]            rd_base_o,
  output logic [CW-1:0]            count_o,
  output logic [31:0]              host_rdata_o,
  output logic [7:0]               eng_rdata_o
);
  logic [CW-1:0] count_q, n_bytes, free_slots, take_n, put_n, push_n, pop_n;
  logic [AW-1:0] head_q, tail_q;
  logic [7:0]    last_q, fill_byte;
  logic [LW-1:0] fill_idx;
  logic          is_wr, host_rd, host_wr, eng_wr, eng_rd;

  assign is_wr      = (dir_i == DIR_WR);
  assign n_bytes    = CW'(lane_count(host_size_i));
  assign free_slots = CW'(DEPTH) - count_q;
  assign host_rd    = host_req_i && !host_we_i && !is_wr;
  assign host_wr    = host_req_i &&  host_we_i &&  is_wr;
  assign eng_wr     = eng_push_i && !is_wr && (count_q != CW'(DEPTH));
  assign eng_rd     = eng_pop_i  &&  is_wr && (count_q != '0);
  assign take_n     = (count_q < n_bytes) ? count_q : n_bytes;
  assign put_n      = (free_slots < n_bytes) ? free_slots : n_bytes;
  assign push_n     = is_wr ? (host_wr ? put_n : '0) : CW'(eng_wr);
  assign pop_n      = is_wr ? CW'(eng_rd) : (host_rd ? take_n : '0);

  // lanes past the free space all target the slot filled last
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      wr_en_o[k]   = 1'b0;
      wr_addr_o[k] = tail_q;
      wr_data_o[k] = host_wdata_i[8*k +: 8];
      if (is_wr) begin
        wr_en_o[k]   = host_wr && (CW'(k) < n_bytes);
        wr_addr_o[k] = (CW'(k) < put_n) ? tail_q + AW'(k)
                                        : tail_q + AW'(put_n) - AW'(1);
      end else if (k == 0) begin
        wr_en_o[k]   = eng_wr;
        wr_data_o[k] = eng_wdata_i;
      end
    end
  end

  assign fill_idx  = (count_q >= CW'(LANES)) ? LW'(LANES - 1) : LW'(count_q - CW'(1));
  assign fill_byte = (count_q == '0) ? last_q : rd_lanes_i[fill_idx];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      host_rdata_o[8*k +: 8] = (CW'(k) < count_q) ? rd_lanes_i[k] : fill_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      last_q  <= 8'h00;
    end else begin
      count_q <= count_q + push_n - pop_n;
      head_q  <= head_q + AW'(pop_n);
      tail_q  <= tail_q + AW'(push_n);
      if (host_rd && take_n != '0) last_q <= rd_lanes_i[LW'(take_n - CW'(1))];
    end
  end

  assign rd_base_o   = head_q;
  assign count_o     = count_q;
  assign eng_rdata_o = rd_lanes_i[0];
endmodule

// File: rtl/byte_fifo_status.sv
module byte_fifo_status
  import byte_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned TW    = 7
) (
  input  logic          dir_i,
  input  logic [CW-1:0] count_i,
  input  logic [TW-1:0] thresh_i,
  output logic [CW-1:0] ptr_o,
  output logic          req_o,
  output logic          eng_ready_o
);
  localparam int unsigned MW = (CW > TW) ? CW : TW;

  assign ptr_o       = (dir_i == DIR_WR) ? CW'(DEPTH) - count_i : count_i;
  assign req_o       = MW'(ptr_o) >= MW'(thresh_i);
  assign eng_ready_o = (dir_i == DIR_WR) ? (count_i != '0) : (count_i != CW'(DEPTH));
endmodule

// File: rtl/byte_fifo_host.sv
module byte_fifo_host
  import byte_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned TW    = 7,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          eng_push_i,
  input  logic [7:0]    eng_wdata_i,
  input  logic          eng_pop_i,
  output logic [7:0]    eng_rdata_o,
  output logic          eng_ready_o,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [1:0]    host_size_i,
  input  logic [31:0]   host_wdata_i,
  output logic [31:0]   host_rdata_o,
  output logic [CW-1:0] fifo_ptr_o,
  output logic          dma_req_o
);
  logic [LANES-1:0]         wr_en;
  logic [LANES-1:0][AW-1:0] wr_addr;
  logic [LANES-1:0][7:0]    wr_data, rd_lanes;
  logic [AW-1:0]            rd_base;
  logic [CW-1:0]            count;

  byte_fifo_store #(.DEPTH(DEPTH), .LANES(LANES), .AW(AW)) store_i (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_base_i (rd_base),
    .rd_data_o (rd_lanes)
  );

  byte_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_i        (dir_i),
    .eng_push_i   (eng_push_i),
    .eng_wdata_i  (eng_wdata_i),
    .eng_pop_i    (eng_pop_i),
    .host_req_i   (host_req_i),
    .host_we_i    (host_we_i),
    .host_size_i  (host_size_i),
    .host_wdata_i (host_wdata_i),
    .rd_lanes_i   (rd_lanes),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .rd_base_o    (rd_base),
    .count_o      (count),
    .host_rdata_o (host_rdata_o),
    .eng_rdata_o  (eng_rdata_o)
  );

  byte_fifo_status #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) status_i (
    .dir_i       (dir_i),
    .count_i     (count),
    .thresh_i    (thresh_i),
    .ptr_o       (fifo_ptr_o),
    .req_o       (dma_req_o),
    .eng_ready_o (eng_ready_o)
  );
endmodule

// File: rtl/byte_fifo_host_chk.sv
module byte_fifo_host_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned TW    = 7,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dir_i,
  input logic [TW-1:0] thresh_i,
  input logic          eng_push_i,
  input logic          eng_pop_i,
  input logic          eng_ready_o,
  input logic          host_req_i,
  input logic          host_we_i,
  input logic [1:0]    host_size_i,
  input logic [31:0]   host_rdata_o,
  input logic [CW-1:0] fifo_ptr_o,
  input logic          dma_req_o
);
  // R1
  eng_fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && eng_push_i && !host_req_i && fifo_ptr_o < CW'(DEPTH))
    |=> fifo_ptr_o == $past(fifo_ptr_o) + CW'(1));

  // R2
  eng_drain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && eng_pop_i && !host_req_i && fifo_ptr_o < CW'(DEPTH))
    |=> fifo_ptr_o == $past(fifo_ptr_o) + CW'(1));

  // R4
  empty_lanes_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && host_req_i && !host_we_i && host_size_i[1] && fifo_ptr_o == '0)
    |-> (host_rdata_o[31:24] == host_rdata_o[7:0] &&
         host_rdata_o[23:16] == host_rdata_o[7:0] &&
         host_rdata_o[15:8]  == host_rdata_o[7:0]));

  // R6
  full_write_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && host_req_i && host_we_i && !eng_pop_i && fifo_ptr_o == '0)
    |=> fifo_ptr_o == '0);

  // R7
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> (int'(fifo_ptr_o) >= int'(thresh_i)));

  // R8
  wrong_dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && host_req_i && host_we_i && !eng_push_i) |=> $stable(fifo_ptr_o));

  // R9
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ptr_o <= CW'(DEPTH));

  // R11
  full_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && fifo_ptr_o == CW'(DEPTH)) |-> !eng_ready_o);
endmodule

bind byte_fifo_host byte_fifo_host_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dir_i        (dir_i),
  .thresh_i     (thresh_i),
  .eng_push_i   (eng_push_i),
  .eng_pop_i    (eng_pop_i),
  .eng_ready_o  (eng_ready_o),
  .host_req_i   (host_req_i),
  .host_we_i    (host_we_i),
  .host_size_i  (host_size_i),
  .host_rdata_o (host_rdata_o),
  .fifo_ptr_o   (fifo_ptr_o),
  .dma_req_o    (dma_req_o)
);

// File: tb/byte_fifo_host_tb_top.sv
`timescale 1ns/1ps
module byte_fifo_host_tb_top;
  localparam int DEPTH = 64;
  localparam int TW    = 7;
  localparam int CW    = 7;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dir_i = 1'b0;
  logic [TW-1:0] thresh_i = '0;
  logic          eng_push_i = 1'b0, eng_pop_i = 1'b0;
  logic [7:0]    eng_wdata_i = '0;
  logic [7:0]    eng_rdata_o;
  logic          eng_ready_o;
  logic          host_req_i = 1'b0, host_we_i = 1'b0;
  logic [1:0]    host_size_i = '0;
  logic [31:0]   host_wdata_i = '0;
  logic [31:0]   host_rdata_o;
  logic [CW-1:0] fifo_ptr_o;
  logic          dma_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mq[$];
  logic [7:0] mlast;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  byte_fifo_host #(.DEPTH(DEPTH), .TW(TW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_ptr();
    return dir_i ? DEPTH - mq.size() : mq.size();
  endfunction

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic do_reset(input logic d);
    rst_ni = 1'b0;
    dir_i  = d;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    mq.delete();
    mlast = 8'h00;
    #2;
    chk("R9 level after reset", 32'(fifo_ptr_o), 32'(exp_ptr()));
  endtask

  // one cycle: optional host access plus optional engine push/pop
  task automatic step(input bit hr, input bit hw, input logic [1:0] sz, input logic [31:0] wd,
                      input bit ep, input logic [7:0] eb, input bit eo);
    int n, lvl, take, put;
    logic [7:0] e;
    host_req_i = hr; host_we_i = hw; host_size_i = sz; host_wdata_i = wd;
    eng_push_i = ep; eng_wdata_i = eb; eng_pop_i = eo;
    #1;
    n = nb(sz);
    lvl = mq.size();
    if (hr && !hw && !dir_i) begin
      for (int k = 0; k < n; k++) begin
        if (k < lvl)      e = mq[k];
        else if (lvl > 0) e = mq[lvl-1];
        else              e = mlast;
        chk((lvl == 0) ? "R4 empty lane" : (k >= lvl) ? "R5 short lane" : "R3 read lane",
            32'(host_rdata_o[8*k +: 8]), 32'(e));
      end
    end
    if (eo && dir_i && lvl > 0) chk("R3 engine byte", 32'(eng_rdata_o), 32'(mq[0]));
    if (!dir_i) begin
      if (hr && !hw) begin
        take = (lvl < n) ? lvl : n;
        for (int k = 0; k < take; k++) mlast = mq.pop_front();
      end
      if (ep && lvl < DEPTH) mq.push_back(eb);
    end else begin
      if (hr && hw) begin
        put = ((DEPTH - lvl) < n) ? DEPTH - lvl : n;
        for (int k = 0; k < put; k++) mq.push_back(wd[8*k +: 8]);
        if (n > put) mq[mq.size()-1] = wd[8*(n-1) +: 8];
      end
      if (eo && lvl > 0) void'(mq.pop_front());
    end
    @(posedge clk_i);
    #1;
    host_req_i = 0; eng_push_i = 0; eng_pop_i = 0;
    #1;
    chk(dir_i ? "R2 level" : "R1 level", 32'(fifo_ptr_o), 32'(exp_ptr()));
    chk("R7 request", 32'(dma_req_o), 32'(exp_ptr() >= int'(thresh_i)));
    chk("R11 ready", 32'(eng_ready_o), 32'(dir_i ? (mq.size() > 0) : (mq.size() < DEPTH)));
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // read direction
    thresh_i = 7'd8;
    do_reset(1'b0);
    chk("R9 request low", 32'(dma_req_o), 32'd0);
    for (int s = 0; s < 3; s++) step(1, 0, 2'(s), 0, 0, 0, 0);         // R4 zero after reset
    for (int i = 0; i < DEPTH; i++) begin
      thresh_i = 7'((i * 5) % 80);
      step(0, 0, 0, 0, 1, 8'(i * 7 + 3), 0);                           // R1 fill
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'hEE, 0);          // R8 push when full
    step(1, 1, 2'd2, 32'hDEADBEEF, 0, 0, 0);                            // R8 host write wrong dir
    step(0, 0, 0, 0, 0, 0, 1);                                          // R8 engine pop wrong dir
    for (int i = 0; mq.size() > 0; i++) begin
      thresh_i = 7'((i * 11) % 70);
      step(1, 0, 2'(i % 3), 0, 0, 0, 0);                               // R3 R5 drain
    end
    for (int s = 0; s < 4; s++) step(1, 0, 2'(s), 0, 0, 0, 0);         // R4 replicate last
    for (int m = 1; m < 4; m++) begin
      for (int i = 0; i < m; i++) step(0, 0, 0, 0, 1, 8'(8'h40 + m * 16 + i), 0);
      step(1, 0, 2'd2, 0, 0, 0, 0);                                    // R5 short word read
      step(1, 0, 2'd1, 0, 0, 0, 0);                                    // R4 then empty
    end
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 8'(8'h90 + i), 0);
    for (int i = 0; i < 12; i++) step(1, 0, 2'(i % 3), 0, 1, 8'(8'hA0 + i), 0); // R10
    while (mq.size() < DEPTH) step(0, 0, 0, 0, 1, 8'(mq.size()), 0);
    step(1, 0, 2'd1, 0, 1, 8'h5A, 0);                                  // R10 push judged on full level
    step(1, 0, 2'd2, 0, 1, 8'h5B, 0);
    // write direction
    thresh_i = 7'd20;
    do_reset(1'b1);
    step(0, 0, 0, 0, 0, 0, 1);                                          // R8 pop when empty
    step(0, 0, 0, 0, 1, 8'h11, 0);                                      // R8 push wrong dir
    step(1, 0, 2'd2, 0, 0, 0, 0);                                       // R8 host read wrong dir
    for (int i = 0; mq.size() < DEPTH; i++) begin
      thresh_i = 7'((i * 13) % 66);
      step(1, 1, 2'(i % 3), 32'(32'h0101_0101 * (i + 1) + 32'h0302_0100), 0, 0, 0); // R2 R6
    end
    for (int s = 0; s < 3; s++) step(1, 1, 2'(s), 32'hC4C3_C2C1 + 32'(s), 0, 0, 0);     // R6 full
    for (int i = 0; i < 10; i++) step(1, 1, 2'd2, 32'(i * 32'h1111_1111), 0, 0, 1);    // R10
    for (int i = 0; mq.size() > 0; i++) step(0, 0, 0, 0, 0, 0, 1);      // R3 drain via engine
    for (int i = 0; i < 6; i++) step(1, 1, 2'(i % 3), 32'h7654_3210 + 32'(i), 0, 0, 1);
    while (mq.size() > 0) step(0, 0, 0, 0, 0, 0, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule